// File: doc/BRIEF.md
# Indexed Pixel Unpacker with Palette

This block sits between a byte-wide framebuffer and a display encoder. It reads packed pixel bytes from a simple asynchronous SRAM-style memory. It splits each byte into one, two, four or eight pixels of 1, 2, 4 or 8 bits each. Every pixel index then goes through an on-chip colour table of 256 entries of 24 bits, and the block delivers one 24-bit RGB pixel for each pixel-enable strobe.

A single shift register serves every depth. The current pixel is always the low bits of that register, masked to the depth width, and the register moves right by the depth after each pixel. The palette of every depth therefore lives in the lowest table slots. The 1-bit depth also goes through the table, so its two colours stay programmable. Grey levels are made by loading equal red, green and blue values into the table. A host port writes table entries one per cycle and selects the depth. A new depth takes effect at the next frame boundary.

The framebuffer address is the byte index inside the frame. It is driven one pixel step ahead of use. A frame holds a parameterised number of pixels, 307200 by default for 640x480.

Top module: `pal_pixel_unpacker`

## Requirements
- R1: After reset, fbAddr is 0, pixValid is 0 and pixOut is 0.
- R2: With depth code 3 (8 bits per pixel), each byte is one pixel and indexes the table directly. Byte 8'b10010011 gives entry 147.
- R3: With depth code 2 (4 bits per pixel), the low nibble is the first pixel and the high nibble the second. Byte 8'b10010011 gives entry 3 and then entry 9.
- R4: With depth code 1 (2 bits) and code 0 (1 bit), pixels leave the byte starting at bit 0. Each pixel indexes the table in slots 0..3 or 0..1 respectively.
- R5: The byte on rdData at one pixEn cycle appears in pixOut only after the next pixEn cycle. pixValid rises after the second pixEn after reset and then stays high.
- R6: fbAddr increases by one once every 8/depth pixEn cycles.
- R7: After byte FRAME_PIXELS*depth/8-1, fbAddr returns to 0 and a new frame starts.
- R8: A depth written through depthWrEn applies from the first pixel of the next frame. The frame in progress keeps its depth to the end.
- R9: A table write to the entry being looked up in the same cycle returns the old colour for that pixel. Later lookups return the new colour.
- R10: In a cycle with pixEn low, fbAddr, pixOut and pixValid keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixEn | input | 1 | Advance one pixel this cycle |
| rdData | input | 8 | Framebuffer byte at fbAddr |
| palWrEn | input | 1 | Colour table write strobe |
| palWrIdx | input | 8 | Colour table entry to write |
| palWrData | input | 24 | Colour value, red in bits 23:16, blue in 7:0 |
| depthWrEn | input | 1 | Depth select write strobe |
| depthWrCode | input | 2 | Depth code: 0=1, 1=2, 2=4, 3=8 bits per pixel |
| fbAddr | output | ADDR_W | Framebuffer byte address |
| pixOut | output | 24 | RGB pixel |
| pixValid | output | 1 | pixOut carries a looked-up pixel |

## Verification
The bench builds the block with FRAME_PIXELS set to 32. At that size, a frame lasts 4 to 32 bytes depending on the depth. The address wrap and depth changes at frame boundaries therefore happen dozens of times within a few thousand cycles. All four depths are exercised, with depth writes that fall mid-frame and on the very cycle of the wrap. The table keeps its full 256 entries, so the collision case and the low-slot palettes of the narrow depths run against a fully loaded table.

// File: rtl/pal_unpack_pkg.sv
package pal_unpack_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    BPP1 = 2'd0,
    BPP2 = 2'd1,
    BPP4 = 2'd2,
    BPP8 = 2'd3
  } bppCode_e;

  typedef struct packed {
    logic     load;   // capture rdData into the shift register
    logic     shift;  // drop the pixel just used
    logic     emit;   // look up the low bits and present the colour
    bppCode_e depth;  // depth of the frame in progress
  } unpackCtrl_t;

  function automatic logic [BYTE_W-1:0] pixMask(bppCode_e c);
    case (c)
      BPP1:    return 8'h01;
      BPP2:    return 8'h03;
      BPP4:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [2:0] lastSlot(bppCode_e c);
    case (c)
      BPP1:    return 3'd7;
      BPP2:    return 3'd3;
      BPP4:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/pal_unpack_ctrl.sv
module pal_unpack_ctrl
  import pal_unpack_pkg::*;
#(
  parameter int       FRAME_PIXELS = 307200,
  parameter bppCode_e RESET_DEPTH  = BPP8,
  localparam int      ADDR_W       = $clog2(FRAME_PIXELS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pixEn,
  input  logic              depthWrEn,
  input  logic [1:0]        depthWrCode,
  output logic [ADDR_W-1:0] fbAddr,
  output unpackCtrl_t       ctrl
);

  bppCode_e    activeDepth;
  bppCode_e    pendingDepth;
  logic [2:0]  slot;
  logic        shValid;
  logic        needLoad;
  bppCode_e    loadDepth;
  logic [ADDR_W-1:0] frameLast;

  function automatic logic [ADDR_W-1:0] lastByteOf(bppCode_e c);
    int unsigned n;
    n = FRAME_PIXELS >> (3 - int'(c));
    return ADDR_W'(n - 1);
  endfunction

  assign needLoad  = !shValid || (slot == lastSlot(activeDepth));
  // The byte at address 0 opens a frame and carries the pending depth.
  assign loadDepth = (fbAddr == '0) ? pendingDepth : activeDepth;
  assign frameLast = lastByteOf(loadDepth);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingDepth <= RESET_DEPTH;
    end else if (depthWrEn) begin
      pendingDepth <= bppCode_e'(depthWrCode);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeDepth <= RESET_DEPTH;
      slot        <= '0;
      shValid     <= 1'b0;
      fbAddr      <= '0;
    end else if (pixEn) begin
      if (needLoad) begin
        slot        <= '0;
        shValid     <= 1'b1;
        activeDepth <= loadDepth;
        fbAddr      <= (fbAddr == frameLast) ? '0 : fbAddr + 1'b1;
      end else begin
        slot <= slot + 3'd1;
      end
    end
  end

  always_comb begin
    ctrl.load  = pixEn && needLoad;
    ctrl.shift = pixEn && !needLoad;
    ctrl.emit  = pixEn && shValid;
    ctrl.depth = activeDepth;
  end

  // R10: the address only moves on a pixel step
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> $stable(fbAddr));

  // R7: the address never leaves the frame of the active depth
  p_addr_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    fbAddr <= lastByteOf(activeDepth));

  // R8: the depth only changes on the load of the first byte of a frame
  p_depth_at_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeDepth) |-> ($past(fbAddr) == '0));

endmodule

// File: rtl/pal_unpack_datapath.sv
module pal_unpack_datapath
  import pal_unpack_pkg::*;
#(
  parameter int  COLOR_W = 24,
  parameter int  INDEX_W = 8,
  localparam int ENTRIES = 1 << INDEX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixEn,
  input  unpackCtrl_t        ctrl,
  input  logic [BYTE_W-1:0]  rdData,
  input  logic               palWrEn,
  input  logic [INDEX_W-1:0] palWrIdx,
  input  logic [COLOR_W-1:0] palWrData,
  output logic [COLOR_W-1:0] pixOut,
  output logic               pixValid
);

  logic [COLOR_W-1:0] palMem [ENTRIES];
  logic [BYTE_W-1:0]  shReg;
  logic [BYTE_W-1:0]  shNext;
  logic [INDEX_W-1:0] pixIdx;

  always_comb begin
    case (ctrl.depth)
      BPP1:    shNext = shReg >> 1;
      BPP2:    shNext = shReg >> 2;
      BPP4:    shNext = shReg >> 4;
      default: shNext = '0;
    endcase
  end

  assign pixIdx = INDEX_W'(shReg & pixMask(ctrl.depth));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (ctrl.load) begin
      shReg <= rdData;
    end else if (ctrl.shift) begin
      shReg <= shNext;
    end
  end

  always_ff @(posedge clk) begin
    if (palWrEn) begin
      palMem[palWrIdx] <= palWrData;
    end
  end

  // The read samples the table before this edge's write lands.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOut   <= '0;
      pixValid <= 1'b0;
    end else if (ctrl.emit) begin
      pixOut   <= palMem[pixIdx];
      pixValid <= 1'b1;
    end
  end

  // R10: the output stays put between pixel steps
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !pixEn |=> ($stable(pixOut) && $stable(pixValid)));

  // R5: once the pipeline is full it stays full
  p_valid_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> pixValid);

  // R5: a pixel is never emitted from a step that did not advance
  p_emit_needs_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.emit |-> pixEn);

endmodule

// File: rtl/pal_pixel_unpacker.sv
module pal_pixel_unpacker
  import pal_unpack_pkg::*;
#(
  parameter int       FRAME_PIXELS = 307200,
  parameter int       COLOR_W      = 24,
  parameter int       INDEX_W      = 8,
  parameter bppCode_e RESET_DEPTH  = BPP8,
  localparam int      ADDR_W       = $clog2(FRAME_PIXELS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixEn,
  input  logic [7:0]         rdData,
  input  logic               palWrEn,
  input  logic [INDEX_W-1:0] palWrIdx,
  input  logic [COLOR_W-1:0] palWrData,
  input  logic               depthWrEn,
  input  logic [1:0]         depthWrCode,
  output logic [ADDR_W-1:0]  fbAddr,
  output logic [COLOR_W-1:0] pixOut,
  output logic               pixValid
);

  unpackCtrl_t ctrl;

  pal_unpack_ctrl #(
    .FRAME_PIXELS (FRAME_PIXELS),
    .RESET_DEPTH  (RESET_DEPTH)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .pixEn       (pixEn),
    .depthWrEn   (depthWrEn),
    .depthWrCode (depthWrCode),
    .fbAddr      (fbAddr),
    .ctrl        (ctrl)
  );

  pal_unpack_datapath #(
    .COLOR_W (COLOR_W),
    .INDEX_W (INDEX_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .pixEn     (pixEn),
    .ctrl      (ctrl),
    .rdData    (rdData),
    .palWrEn   (palWrEn),
    .palWrIdx  (palWrIdx),
    .palWrData (palWrData),
    .pixOut    (pixOut),
    .pixValid  (pixValid)
  );

endmodule

// File: tb/pal_pixel_unpacker_tb_top.sv
`timescale 1ns/1ps
module pal_pixel_unpacker_tb_top;

  localparam int PIX    = 32;
  localparam int ADDR_W = $clog2(PIX);
  localparam real CLK_P = 5.0;

  logic              clk = 1'b0;
  logic              rstN;
  logic              pixEn;
  logic [7:0]        rdData;
  logic              palWrEn;
  logic [7:0]        palWrIdx;
  logic [23:0]       palWrData;
  logic              depthWrEn;
  logic [1:0]        depthWrCode;
  logic [ADDR_W-1:0] fbAddr;
  logic [23:0]       pixOut;
  logic              pixValid;

  logic [7:0]  fbMem  [PIX];
  logic [23:0] refPal [256];

  int checks = 0;
  int errors = 0;

  // model state
  bit          started = 0;
  int          q = 0;
  int          curDepth = 3;
  int          pend = 3;
  bit          frameChanged = 0;
  logic [23:0] expPix = '0;
  logic        expValid = 1'b0;
  int          expAddr = 0;

  always #(CLK_P/2) clk = ~clk;

  assign rdData = fbMem[fbAddr];

  pal_pixel_unpacker #(.FRAME_PIXELS(PIX)) dut_i (
    .clk(clk), .rstN(rstN), .pixEn(pixEn), .rdData(rdData),
    .palWrEn(palWrEn), .palWrIdx(palWrIdx), .palWrData(palWrData),
    .depthWrEn(depthWrEn), .depthWrCode(depthWrCode),
    .fbAddr(fbAddr), .pixOut(pixOut), .pixValid(pixValid));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int bitsOf(int c);
    return 1 << c;
  endfunction

  function automatic int refIdx(int p, int c);
    int b   = bitsOf(c);
    int ppb = 8 / b;
    logic [7:0] by = fbMem[p / ppb];
    return int'((by >> ((p % ppb) * b)) & 8'((1 << b) - 1));
  endfunction

  function automatic string depthTag(int c);
    if (c == 3) return "R2";
    if (c == 2) return "R3";
    return "R4";
  endfunction

  task automatic step(bit pe, bit pw, logic [7:0] pi, logic [23:0] pd,
                      bit dw, logic [1:0] dc);
    string pixTag = "R10";
    string addrTag = "R10";
    int idx = -1;
    pixEn = pe; palWrEn = pw; palWrIdx = pi; palWrData = pd;
    depthWrEn = dw; depthWrCode = dc;
    if (pe) begin
      if (!started) begin
        started = 1; curDepth = pend; q = 0; frameChanged = 0;
      end else begin
        idx = refIdx(q, curDepth);
        expPix = refPal[idx];
        expValid = 1'b1;
        if (pw && pi == 8'(idx)) pixTag = "R9";
        else if (frameChanged) pixTag = "R8";
        else pixTag = depthTag(curDepth);
        q++;
        if (q == PIX) begin
          q = 0;
          frameChanged = (pend != curDepth);
          curDepth = pend;
        end
      end
      begin
        int ppb = 8 / bitsOf(curDepth);
        int bpf = PIX * bitsOf(curDepth) / 8;
        expAddr = ((q / ppb) + 1) % bpf;
        addrTag = (expAddr == 0 || q == 0) ? "R7" : "R6";
      end
    end
    if (pw) refPal[pi] = pd;
    if (dw) pend = int'(dc);
    @(posedge clk);
    @(negedge clk);
    chk(pe ? addrTag : "R10", 32'(fbAddr), 32'(expAddr));
    chk(pe ? "R5" : "R10", 32'(pixValid), 32'(expValid));
    if (expValid) chk(pixTag, 32'(pixOut), 32'(expPix));
    pixEn = 0; palWrEn = 0; depthWrEn = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1, 0, 8'd0, 24'd0, 0, 2'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 0; pixEn = 0; palWrEn = 0; palWrIdx = 0; palWrData = 0;
    depthWrEn = 0; depthWrCode = 0;
    for (int i = 0; i < PIX; i++) fbMem[i] = 8'($urandom);
    fbMem[0] = 8'b10010011;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", 32'(fbAddr), 32'd0);
    chk("R1", 32'(pixValid), 32'd0);
    chk("R1", 32'(pixOut), 32'd0);

    // load the whole table while idle (R10 checked on each cycle)
    for (int i = 0; i < 256; i++) step(0, 1, 8'(i), 24'($urandom), 0, 2'd0);

    // 8-bit frame, then ask for 4-bit mid-frame (R2, R8)
    run(12);
    step(1, 0, 8'd0, 24'd0, 1, 2'd2);
    run(40);
    // 4-bit frames, byte 0 gives 3 then 9 (R3)
    run(30);
    step(1, 0, 8'd0, 24'd0, 1, 2'd1);
    run(70);
    step(1, 0, 8'd0, 24'd0, 1, 2'd0);
    run(70);
    // collisions on the entry being looked up (R9)
    for (int k = 0; k < 6; k++) begin
      int ix = refIdx(q, curDepth);
      step(1, 1, 8'(ix), 24'($urandom), 0, 2'd0);
      run(3);
    end
    // depth write on a wrap cycle: go back to 8 bits
    while (q != PIX - 1) run(1);
    step(1, 0, 8'd0, 24'd0, 1, 2'd3);
    run(40);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit pe = ($urandom % 4) != 0;
      bit pw = ($urandom % 8) == 0;
      bit dw = ($urandom % 64) == 0;
      logic [7:0] wi = (($urandom % 2) == 0) ? 8'($urandom % 4) : 8'($urandom);
      step(pe, pw, wi, 24'($urandom), dw, 2'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule